// File: doc/BRIEF.md
# Programmable I2C SCL Rate Generator

This block paces the clock line of an I2C bus controller. It takes a packed configuration word with two fields: a prescale value that divides the system clock down to an internal bit-timing tick, and a period value that sets how many of those ticks make up one SCL period. The period is always a fixed base of 20 ticks, plus 8 ticks per unit of the period field, plus a build-time compensation count that covers line fall time, rise time and internal delay.

While `run` is high, the block repeats the SCL period. It splits each period into a low phase and a high phase and drives the desired SCL level on `scl_out`. It also gives the bus state machine two single-cycle enables. `chg_en` fires in the middle of the low phase, where SDA may change. `smp_en` fires in the middle of the high phase, where SDA is sampled. The high-phase count only advances on ticks where the real SCL line reads high, so a slave that holds SCL low lengthens the period. The configuration is taken only while the bus is idle, which means a frame in progress keeps its timing.

Top module: `scl_rate_gen`

## Requirements
- R1: The prescale field is `cfg_word[2:0]`. The internal tick occurs once every 1 + prescale system clocks, counted from the cycle in which `run` rises.
- R2: The period field is `cfg_word[8:3]`. Without stretching, successive `smp_en` pulses are (20 + 8·period + COMP_TICKS)·(1 + prescale) clocks apart.
- R3: With period length P ticks, the low phase lasts L = floor(P/2) ticks and the high phase lasts H = P − L ticks. Without stretching, `scl_out` stays high for H·(1 + prescale) clocks, and the enable-spacing rule in R4 holds.
- R4: `chg_en` pulses only while `scl_out` is low, on the tick where the low count equals floor(L/2). `smp_en` pulses only while `scl_out` and `scl_in` are both high, on the tick where the high count equals floor(H/2). So the gap from `chg_en` to the next `smp_en` is (L − floor(L/2) + floor(H/2))·(1 + prescale) clocks, and the two never pulse together.
- R5: During the high phase, a tick on which `scl_in` is low does not advance the count. A stretch covering n ticks lengthens that high phase and that period by n·(1 + prescale) clocks.
- R6: `cfg_word` is captured only in cycles where `bus_idle` is high. A change made while `bus_idle` is low leaves the running timing unchanged.
- R7: While `run` is low, `scl_out` is high, `chg_en` and `smp_en` stay low, and the counters restart. After `run` rises, the first period begins with a full low phase.
- R8: After reset, `scl_out` is high and both enables are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_word | input | 9 | Packed configuration: prescale in [2:0], period in [8:3] |
| bus_idle | input | 1 | High while no frame is in progress; enables configuration capture |
| run | input | 1 | High to generate SCL periods |
| scl_in | input | 1 | Sampled level of the real SCL line |
| scl_out | output | 1 | Desired SCL level (1 = release, 0 = pull low) |
| chg_en | output | 1 | Single-cycle enable in the middle of the low phase |
| smp_en | output | 1 | Single-cycle enable in the middle of the high phase |

## Verification
The hard coincidence is a slave holding SCL low in the same cycle that the prescaler issues a tick during the high phase. That tick must be absorbed without counting, while the prescaler keeps its own cadence. The bench provokes this with a prescale of 2 and a 7-cycle hold that starts at the beginning of a high phase, so two ticks fall inside the hold. It judges the result by requiring that the high time and the period grow by exactly 6 clocks, a whole number of ticks. A finer case, with prescale 0 and a 5-cycle hold, checks the one-clock granularity.

// File: rtl/scl_rate_pkg.sv
// Shared constants for the SCL rate generator.
// Assumes the period formula: BASE + STEP * period_field + compensation ticks.
package scl_rate_pkg;
    localparam int BASE_TICKS = 20;
    localparam int STEP_TICKS = 8;
endpackage

// File: rtl/scl_cfg_latch.sv
// Captures the prescale and period fields of the configuration word.
// Assumes bus_idle marks cycles where no frame uses the timing; the fields
// are held unchanged at all other times.
module scl_cfg_latch #(
    parameter int DIV_W = 3,
    parameter int PER_W = 6,
    localparam int CFG_W = DIV_W + PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             bus_idle,
    output logic [DIV_W-1:0] div_q,
    output logic [PER_W-1:0] per_q
);
    // Sample both fields only while the bus is idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            per_q <= '0;
        end else if (bus_idle) begin
            div_q <= cfg_word[DIV_W-1:0];
            per_q <= cfg_word[CFG_W-1:DIV_W];
        end
    end

    assert_cfg_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_idle |=> ($stable(div_q) && $stable(per_q)));
endmodule

// File: rtl/scl_prescaler.sv
// Divides the system clock into internal ticks, one every 1 + div clocks.
// Assumes div is stable while run is high; it restarts whenever run is low.
module scl_prescaler #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] pre_cnt;

    assign tick = run && (pre_cnt >= div);

    // Count system clocks and wrap on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pre_cnt <= '0;
        end else if (tick) begin
            pre_cnt <= '0;
        end else begin
            pre_cnt <= pre_cnt + 1'b1;
        end
    end

    assert_tick_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (!run || pre_cnt == '0));
    assert_tick_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> (!run || pre_cnt == DIV_W'($past(pre_cnt) + 1'b1)));
    assert_idle_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_cnt == '0));
endmodule

// File: rtl/scl_phase_timer.sv
// Splits each SCL period into a low and a high phase, counted in internal ticks.
// Gives the mid-low change enable and the mid-high sample enable.
// Assumes that a low scl_in during the high phase means a slave is stretching.
module scl_phase_timer #(
    parameter int PER_W = 6,
    parameter int COMP_TICKS = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             scl_in,
    input  logic [PER_W-1:0] per,
    output logic             phase_hi,
    output logic             chg_en,
    output logic             smp_en
);
    import scl_rate_pkg::*;

    localparam int MAX_P = BASE_TICKS + STEP_TICKS * ((1 << PER_W) - 1) + COMP_TICKS;
    localparam int CNT_W = $clog2(MAX_P + 1);

    logic [CNT_W-1:0] period, lo_len, hi_len, mid_lo, mid_hi, cnt;
    logic             lo_last, hi_last;

    // Derive the phase lengths and midpoints from the period field.
    always_comb begin
        period  = CNT_W'(BASE_TICKS) + CNT_W'(STEP_TICKS) * CNT_W'(per) + CNT_W'(COMP_TICKS);
        lo_len  = period >> 1;
        hi_len  = period - lo_len;
        mid_lo  = lo_len >> 1;
        mid_hi  = hi_len >> 1;
        lo_last = (cnt >= lo_len - 1'b1);
        hi_last = (cnt >= hi_len - 1'b1);
    end

    assign chg_en = run && tick && !phase_hi && (cnt == mid_lo);
    assign smp_en = run && tick && phase_hi && scl_in && (cnt == mid_hi);

    // Advance the phase count on ticks; freeze the high count while SCL is held low.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_hi <= 1'b0;
            cnt      <= '0;
        end else if (tick) begin
            if (!phase_hi) begin
                if (lo_last) begin
                    phase_hi <= 1'b1;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (scl_in) begin
                if (hi_last) begin
                    phase_hi <= 1'b0;
                    cnt      <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && phase_hi && tick && !scl_in) |=> (!run || (phase_hi && $stable(cnt))));
    assert_start_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (!phase_hi && cnt == '0));
endmodule

// File: rtl/scl_rate_gen.sv
// Top of the SCL rate generator: configuration capture, prescaler and phase timer.
// Assumes scl_in is already synchronised to clk; scl_out is the desired line level.
module scl_rate_gen #(
    parameter int DIV_W = 3,
    parameter int PER_W = 6,
    parameter int COMP_TICKS = 5,
    localparam int CFG_W = DIV_W + PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             bus_idle,
    input  logic             run,
    input  logic             scl_in,
    output logic             scl_out,
    output logic             chg_en,
    output logic             smp_en
);
    logic [DIV_W-1:0] div_q;
    logic [PER_W-1:0] per_q;
    logic             tick;
    logic             phase_hi;

    scl_cfg_latch #(.DIV_W(DIV_W), .PER_W(PER_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .bus_idle(bus_idle),
        .div_q(div_q), .per_q(per_q)
    );

    scl_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .div(div_q), .tick(tick)
    );

    scl_phase_timer #(.PER_W(PER_W), .COMP_TICKS(COMP_TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .scl_in(scl_in),
        .per(per_q), .phase_hi(phase_hi), .chg_en(chg_en), .smp_en(smp_en)
    );

    // Release SCL whenever the generator is stopped.
    assign scl_out = phase_hi || !run;

    assert_chg_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en |-> (!scl_out && !smp_en));
    assert_smp_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smp_en |-> (scl_out && scl_in));
    assert_stop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (scl_out && !chg_en && !smp_en));
endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
    localparam int COMP = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] cfg_word = '0;
    logic       bus_idle = 1'b1;
    logic       run = 1'b0;
    logic       stretch = 1'b0;
    logic       scl_in, scl_out, chg_en, smp_en;

    int checks = 0;
    int errors = 0;

    assign scl_in = scl_out & ~stretch;

    always #10 clk = ~clk;

    scl_rate_gen #(.DIV_W(3), .PER_W(6), .COMP_TICKS(COMP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .bus_idle(bus_idle),
        .run(run), .scl_in(scl_in), .scl_out(scl_out), .chg_en(chg_en), .smp_en(smp_en)
    );

    int int_q[$];
    int gap_q[$];
    int hi_q[$];
    int cyc = 0;
    int last_smp = 0;
    int chg_t = 0;
    int rise_t = 0;
    bit arm = 1'b0;
    bit chg_v = 1'b0;
    bit rise_v = 1'b0;
    bit prev_scl = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures enable spacing and high time, compares against the queues.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (chg_en) begin
                chg_t = cyc;
                chg_v = 1'b1;
            end
            if (smp_en) begin
                if (chg_v && gap_q.size() > 0) begin
                    int e;
                    e = gap_q.pop_front();
                    check(cyc - chg_t == e, "R4 chg-to-smp gap", cyc - chg_t, e);
                end
                if (arm) begin
                    arm = 1'b0;
                end else if (int_q.size() > 0) begin
                    int e;
                    e = int_q.pop_front();
                    check(cyc - last_smp == e, "R2/R1/R5 smp interval", cyc - last_smp, e);
                end
                last_smp = cyc;
            end
            if (scl_out && !prev_scl) begin
                rise_t = cyc;
                rise_v = 1'b1;
            end
            if (!scl_out && prev_scl && rise_v) begin
                rise_v = 1'b0;
                if (hi_q.size() > 0) begin
                    int e;
                    e = hi_q.pop_front();
                    check(cyc - rise_t == e, "R3/R5 high time", cyc - rise_t, e);
                end
            end
            prev_scl = scl_out;
        end
    end

    task automatic wait_rise();
        while (scl_out !== 1'b0) @(negedge clk);
        while (scl_out !== 1'b1) @(negedge clk);
    endtask

    // Driver: computes expectations from the requirements and runs one case.
    task automatic run_case(input int div, input int per, input int hold, input bit chg_cfg);
        int p, l, h, c1, g, ext, t;
        c1  = div + 1;
        p   = 20 + 8 * per + COMP;
        l   = p / 2;
        h   = p - l;
        g   = (l - l / 2 + h / 2) * c1;
        ext = (hold / c1) * c1;
        @(negedge clk);
        run = 1'b0;
        bus_idle = 1'b1;
        cfg_word = {per[5:0], div[2:0]};
        repeat (3) @(negedge clk);
        if (hold > 0) begin
            int_q.push_back(p * c1 + ext); int_q.push_back(p * c1);
            gap_q.push_back(g); gap_q.push_back(g + ext); gap_q.push_back(g);
            hi_q.push_back(h * c1); hi_q.push_back(h * c1 + ext); hi_q.push_back(h * c1);
        end else begin
            repeat (2) begin
                int_q.push_back(p * c1);
                gap_q.push_back(g);
                hi_q.push_back(h * c1);
            end
        end
        arm = 1'b1; chg_v = 1'b0; rise_v = 1'b0;
        bus_idle = 1'b0;
        run = 1'b1;
        if (chg_cfg) begin
            repeat (4) @(negedge clk);
            cfg_word = 9'h1FF;
        end
        if (hold > 0) begin
            wait_rise();
            wait_rise();
            stretch = 1'b1;
            repeat (hold) @(negedge clk);
            stretch = 1'b0;
        end
        t = 0;
        while ((int_q.size() + gap_q.size() + hi_q.size()) > 0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(t < 5000, "R2 expected events all seen", t, 0);
        run = 1'b0;
        bus_idle = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int pulses;
        int lows;
        repeat (3) @(negedge clk);
        // R8: reset state
        check(scl_out == 1'b1, "R8 scl_out after reset", scl_out, 1);
        check(chg_en == 1'b0, "R8 chg_en after reset", chg_en, 0);
        check(smp_en == 1'b0, "R8 smp_en after reset", smp_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_case(0, 0, 0, 1'b0);    // R2 base period 25 ticks
        run_case(2, 1, 0, 1'b0);    // R1 prescale 2
        run_case(7, 5, 0, 1'b0);    // R1 max prescale
        run_case(0, 63, 0, 1'b0);   // R2 max period field
        run_case(0, 0, 5, 1'b0);    // R5 stretch, one-clock ticks
        run_case(2, 1, 7, 1'b0);    // R5 stretch spanning two ticks
        run_case(1, 2, 0, 1'b1);    // R6 config change while busy is ignored

        // R7: stopped generator stays quiet with SCL released
        pulses = 0;
        lows = 0;
        repeat (40) begin
            @(negedge clk);
            if (chg_en || smp_en) pulses++;
            if (!scl_out) lows++;
        end
        check(pulses == 0, "R7 no enables while stopped", pulses, 0);
        check(lows == 0, "R7 scl_out high while stopped", lows, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule